// File: doc/BRIEF.md
# Ticket Lock Unit

The block serves a small set of mutual-exclusion locks to a fixed group of requesters and grants each lock strictly in the order that the acquires arrived. Every lock holds two counters: a dispenser that hands out tickets and a turn counter that names the ticket whose turn it is. When an idle requester raises an acquire, the dispenser of the chosen lock gives it the current count and then increments, all in the arrival cycle. This happens whether or not the lock is free at that moment. The requester keeps its ticket in a private slot register, and its grant stays high for as long as the turn counter equals that ticket.

A release from the requester that currently holds its lock advances the turn counter by one, so the lock passes to the next ticket without any retry traffic. A release from a requester that does not hold a lock changes nothing and raises a one-cycle error pulse. Both counters wrap modulo 2^TW, with TW = clog2(NUM_REQ)+1. Because no more than NUM_REQ tickets can be outstanding, equality after wrap is never ambiguous.

Top module: `ticket_lock_unit`

## Requirements
- R1: After reset all counters are 0, and every grant_o, err_o and ticket_o field reads 0.
- R2: An acquire from an idle requester loads the chosen lock's dispenser value into that requester's ticket_o field at the next clock edge and increments the dispenser by one.
- R3: Acquires to the same lock in one cycle receive consecutive tickets in ascending requester-index order, with the lowest index getting the current dispenser value.
- R4: grant_o[r] is high exactly while requester r holds a ticket and that ticket equals its lock's turn counter. A requester whose lock is free sees its grant in the cycle after its acquire.
- R5: No more than one requester is granted for any lock at any time, and grants follow ticket order.
- R6: A release from the granted requester advances its lock's turn counter by one at the clock edge, returns the requester to idle, and grants the next ticket holder in the following cycle.
- R7: A release from a requester that is not granted leaves all state unchanged, and err_o of that requester is high for exactly the one cycle after the release cycle.
- R8: An acquire from a requester that already holds a ticket is ignored: neither its ticket nor the dispenser changes.
- R9: Tickets and turn counters wrap modulo 2^TW (8 with the default of 4 requesters), and ordering and grants stay correct across the wrap.
- R10: A release by the holder and an acquire by another requester to the same lock in the same cycle both take effect.
- R11: Locks are independent, so requesters on different locks can hold grants at the same time. acq_lock_i field r selects the lock (0 or 1 with the defaults).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| acq_i | input | NUM_REQ | Acquire request, one bit per requester |
| acq_lock_i | input | NUM_REQ*LW | Lock index for each requester's acquire, field r at bits r*LW |
| rel_i | input | NUM_REQ | Release request, one bit per requester |
| grant_o | output | NUM_REQ | Requester currently owns its lock |
| ticket_o | output | NUM_REQ*TW | Ticket held by each requester (last one taken) |
| err_o | output | NUM_REQ | One-cycle pulse after a release by a non-holder |

## Verification
Three things can land in one cycle: a holder's release, a fresh acquire to the same lock, and a queued acquire from the same requester. The bench drives a release from the holder together with another requester's acquire to that lock. With an empty queue, the newcomer's ticket must equal the advanced turn counter, so it has to be granted right after that edge. Several requesters acquiring one lock together, and a busy requester re-acquiring in the same cycle as a fresh requester, are judged by the ticket values read from ticket_o against a dispenser model kept in the bench.

// File: rtl/ticket_lock_pkg.sv
package ticket_lock_pkg;

  typedef enum logic {
    SLOT_IDLE = 1'b0,
    SLOT_HELD = 1'b1
  } slot_e;

  function automatic int ticket_bits(input int n_req);
    return $clog2(n_req) + 1;
  endfunction

  function automatic int lock_bits(input int n_locks);
    return (n_locks > 1) ? $clog2(n_locks) : 1;
  endfunction

endpackage

// File: rtl/lock_counters.sv
module lock_counters #(
  parameter int NUM_REQ = 4,
  parameter int TW      = 3
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_REQ-1:0]    take_i,
  input  logic                  adv_i,
  output logic [TW-1:0]         next_o,
  output logic [TW-1:0]         serving_o,
  output logic [NUM_REQ*TW-1:0] offer_o
);

  logic [TW-1:0] next_q, next_d, serving_q;

  // ascending index gets consecutive tickets
  always_comb begin
    logic [TW-1:0] run;
    run = next_q;
    offer_o = '0;
    for (int r = 0; r < NUM_REQ; r++) begin
      offer_o[r*TW +: TW] = run;
      if (take_i[r]) run = run + TW'(1);
    end
    next_d = run;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      next_q    <= '0;
      serving_q <= '0;
    end else begin
      next_q <= next_d;
      if (adv_i) serving_q <= serving_q + TW'(1);
    end
  end

  assign next_o    = next_q;
  assign serving_o = serving_q;

endmodule

// File: rtl/req_slot.sv
module req_slot import ticket_lock_pkg::*; #(
  parameter int LW = 1,
  parameter int TW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          acq_i,
  input  logic [LW-1:0] lock_i,
  input  logic          rel_i,
  input  logic [TW-1:0] offer_i,
  input  logic [TW-1:0] serving_i,
  output logic          take_o,
  output logic          busy_o,
  output logic [LW-1:0] lock_o,
  output logic [TW-1:0] ticket_o,
  output logic          grant_o,
  output logic          rel_ok_o,
  output logic          err_o
);

  slot_e         state_q;
  logic [LW-1:0] lock_q;
  logic [TW-1:0] ticket_q;
  logic          err_q;

  assign busy_o   = (state_q == SLOT_HELD);
  assign take_o   = acq_i && !busy_o;
  assign grant_o  = busy_o && (ticket_q == serving_i);
  assign rel_ok_o = rel_i && grant_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= SLOT_IDLE;
      lock_q   <= '0;
      ticket_q <= '0;
      err_q    <= 1'b0;
    end else begin
      err_q <= rel_i && !grant_o;
      if (rel_ok_o) begin
        state_q <= SLOT_IDLE;
      end else if (take_o) begin
        state_q  <= SLOT_HELD;
        lock_q   <= lock_i;
        ticket_q <= offer_i;
      end
    end
  end

  assign lock_o   = lock_q;
  assign ticket_o = ticket_q;
  assign err_o    = err_q;

endmodule

// File: rtl/ticket_lock_unit.sv
module ticket_lock_unit import ticket_lock_pkg::*; #(
  parameter  int NUM_REQ   = 4,
  parameter  int NUM_LOCKS = 2,
  localparam int TW        = ticket_bits(NUM_REQ),
  localparam int LW        = lock_bits(NUM_LOCKS)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_REQ-1:0]    acq_i,
  input  logic [NUM_REQ*LW-1:0] acq_lock_i,
  input  logic [NUM_REQ-1:0]    rel_i,
  output logic [NUM_REQ-1:0]    grant_o,
  output logic [NUM_REQ*TW-1:0] ticket_o,
  output logic [NUM_REQ-1:0]    err_o
);

  logic [NUM_LOCKS-1:0][TW-1:0]         next_q;
  logic [NUM_LOCKS-1:0][TW-1:0]         serving_q;
  logic [NUM_LOCKS-1:0][NUM_REQ*TW-1:0] offers;
  logic [NUM_LOCKS-1:0][NUM_REQ-1:0]    take_mask;
  logic [NUM_LOCKS-1:0]                 lock_adv;

  logic [NUM_REQ-1:0]         take, rel_ok, busy;
  logic [NUM_REQ-1:0][LW-1:0] slot_lock;
  logic [NUM_REQ-1:0][TW-1:0] offer_sel, serve_sel;

  // route acquires and releases to their lock
  always_comb begin
    take_mask = '0;
    lock_adv  = '0;
    for (int l = 0; l < NUM_LOCKS; l++) begin
      for (int r = 0; r < NUM_REQ; r++) begin
        take_mask[l][r] = take[r] && (acq_lock_i[r*LW +: LW] == LW'(l));
        if (rel_ok[r] && (slot_lock[r] == LW'(l))) lock_adv[l] = 1'b1;
      end
    end
  end

  // pick each requester's offered ticket and its lock's turn counter
  always_comb begin
    offer_sel = '0;
    serve_sel = '0;
    for (int r = 0; r < NUM_REQ; r++) begin
      for (int l = 0; l < NUM_LOCKS; l++) begin
        if (acq_lock_i[r*LW +: LW] == LW'(l)) offer_sel[r] = offers[l][r*TW +: TW];
        if (slot_lock[r] == LW'(l))           serve_sel[r] = serving_q[l];
      end
    end
  end

  for (genvar l = 0; l < NUM_LOCKS; l++) begin : g_lock
    lock_counters #(
      .NUM_REQ (NUM_REQ),
      .TW      (TW)
    ) u_ctr (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .take_i    (take_mask[l]),
      .adv_i     (lock_adv[l]),
      .next_o    (next_q[l]),
      .serving_o (serving_q[l]),
      .offer_o   (offers[l])
    );
  end

  for (genvar r = 0; r < NUM_REQ; r++) begin : g_slot
    req_slot #(
      .LW (LW),
      .TW (TW)
    ) u_slot (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .acq_i     (acq_i[r]),
      .lock_i    (acq_lock_i[r*LW +: LW]),
      .rel_i     (rel_i[r]),
      .offer_i   (offer_sel[r]),
      .serving_i (serve_sel[r]),
      .take_o    (take[r]),
      .busy_o    (busy[r]),
      .lock_o    (slot_lock[r]),
      .ticket_o  (ticket_o[r*TW +: TW]),
      .grant_o   (grant_o[r]),
      .rel_ok_o  (rel_ok[r]),
      .err_o     (err_o[r])
    );
  end

endmodule

// File: rtl/ticket_lock_checker.sv
module ticket_lock_checker #(
  parameter int NUM_REQ   = 4,
  parameter int NUM_LOCKS = 2,
  parameter int TW        = 3,
  parameter int LW        = 1
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic [NUM_REQ-1:0]           rel_i,
  input logic [NUM_REQ-1:0]           grant_o,
  input logic [NUM_REQ-1:0]           err_o,
  input logic [NUM_REQ-1:0]           busy,
  input logic [NUM_REQ-1:0][LW-1:0]   slot_lock,
  input logic [NUM_LOCKS-1:0][TW-1:0] next_q,
  input logic [NUM_LOCKS-1:0][TW-1:0] serving_q,
  input logic [NUM_LOCKS-1:0]         lock_adv
);

  function automatic logic [NUM_REQ-1:0] owned_by(input int l);
    logic [NUM_REQ-1:0] m;
    for (int r = 0; r < NUM_REQ; r++) m[r] = busy[r] && (slot_lock[r] == LW'(l));
    return m;
  endfunction

  for (genvar l = 0; l < NUM_LOCKS; l++) begin : g_lk
    a_r5_single_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $countones(grant_o & owned_by(l)) <= 1);
    a_r6_turn_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lock_adv[l] |=> serving_q[l] == $past(serving_q[l]) + TW'(1));
    a_r7_turn_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !lock_adv[l] |=> $stable(serving_q[l]));
    a_r9_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
      int'(TW'(next_q[l] - serving_q[l])) <= NUM_REQ);
  end

  for (genvar r = 0; r < NUM_REQ; r++) begin : g_rq
    a_r4_grant_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
      grant_o[r] |-> busy[r]);
    a_r7_err_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rel_i[r] && !grant_o[r]) |=> err_o[r]);
    a_r7_err_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(rel_i[r] && !grant_o[r]) |=> !err_o[r]);
  end

endmodule

bind ticket_lock_unit ticket_lock_checker #(
  .NUM_REQ   (NUM_REQ),
  .NUM_LOCKS (NUM_LOCKS),
  .TW        (TW),
  .LW        (LW)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .rel_i     (rel_i),
  .grant_o   (grant_o),
  .err_o     (err_o),
  .busy      (busy),
  .slot_lock (slot_lock),
  .next_q    (next_q),
  .serving_q (serving_q),
  .lock_adv  (lock_adv)
);

// File: tb/ticket_lock_unit_bench.sv
module ticket_lock_unit_bench;

  localparam int CLK_PERIOD = 10;
  localparam int N  = 4;
  localparam int TW = 3;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] acq = '0, lk = '0, rel = '0;
  logic [N-1:0] grant, err;
  logic [N*TW-1:0] ticket;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [TW-1:0] exp_next [2];
  logic [TW-1:0] exp_serv [2];
  logic [TW-1:0] exp_tk   [N];
  logic          exp_lk   [N];
  logic [N-1:0]  exp_busy, exp_err;

  always #(CLK_PERIOD/2) clk = ~clk;

  ticket_lock_unit u_ticket_lock_unit (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .acq_i      (acq),
    .acq_lock_i (lk),
    .rel_i      (rel),
    .grant_o    (grant),
    .ticket_o   (ticket),
    .err_o      (err)
  );

  function automatic logic exp_grant(input int r);
    return exp_busy[r] && (exp_tk[r] == exp_serv[exp_lk[r]]);
  endfunction

  task automatic check_all(input string tag);
    for (int r = 0; r < N; r++) begin
      checks++;
      if (grant[r] !== exp_grant(r)) begin
        errors++;
        $display("FAIL %s grant[%0d] actual %b expected %b", tag, r, grant[r], exp_grant(r));
      end
      checks++;
      if (ticket[r*TW +: TW] !== exp_tk[r]) begin
        errors++;
        $display("FAIL %s ticket[%0d] actual %0d expected %0d", tag, r, ticket[r*TW +: TW], exp_tk[r]);
      end
      checks++;
      if (err[r] !== exp_err[r]) begin
        errors++;
        $display("FAIL %s err[%0d] actual %b expected %b", tag, r, err[r], exp_err[r]);
      end
    end
  endtask

  // one clock: drive at negedge, update model, check at next negedge
  task automatic cyc(input logic [N-1:0] a, input logic [N-1:0] l,
                     input logic [N-1:0] rl, input string tag);
    logic [N-1:0] busy_b, grant_b;
    for (int r = 0; r < N; r++) grant_b[r] = exp_grant(r);
    busy_b = exp_busy;
    acq = a; lk = l; rel = rl;
    for (int r = 0; r < N; r++) begin
      exp_err[r] = 1'b0;
      if (rl[r]) begin
        if (grant_b[r]) begin
          exp_serv[exp_lk[r]] = exp_serv[exp_lk[r]] + 1'b1;
          exp_busy[r] = 1'b0;
        end else exp_err[r] = 1'b1;
      end
    end
    for (int r = 0; r < N; r++) begin
      if (a[r] && !busy_b[r]) begin
        exp_tk[r]   = exp_next[l[r]];
        exp_next[l[r]] = exp_next[l[r]] + 1'b1;
        exp_busy[r] = 1'b1;
        exp_lk[r]   = l[r];
      end
    end
    @(negedge clk);
    acq = '0; rel = '0;
    check_all(tag);
  endtask

  task automatic t_reset;
    for (int i = 0; i < 2; i++) begin exp_next[i] = '0; exp_serv[i] = '0; end
    for (int r = 0; r < N; r++) begin exp_tk[r] = '0; exp_lk[r] = 1'b0; end
    exp_busy = '0; exp_err = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check_all("R1 reset");
    @(negedge clk);
    check_all("R1 idle");
  endtask

  task automatic t_single;
    cyc(4'b0001, 4'b0000, 4'b0000, "R2 R4 single acquire");
    cyc(4'b0000, 4'b0000, 4'b0001, "R6 single release");
  endtask

  task automatic t_simul;
    cyc(4'b1111, 4'b0000, 4'b0000, "R3 R5 four acquires");
    cyc(4'b0000, 4'b0000, 4'b0001, "R6 hand to r1");
    cyc(4'b0000, 4'b0000, 4'b0010, "R6 hand to r2");
    cyc(4'b0000, 4'b0000, 4'b0100, "R5 hand to r3");
    cyc(4'b0000, 4'b0000, 4'b1000, "R6 drain");
  endtask

  task automatic t_stray;
    cyc(4'b0001, 4'b0000, 4'b0000, "R4 r0 holds");
    cyc(4'b0010, 4'b0000, 4'b0000, "R4 r1 queued");
    cyc(4'b0000, 4'b0000, 4'b0010, "R7 waiter release");
    cyc(4'b0000, 4'b0000, 4'b0000, "R7 pulse ends");
    cyc(4'b0110, 4'b0000, 4'b0000, "R8 busy reacquire");
    cyc(4'b0000, 4'b0000, 4'b0100, "R7 idle-side release");
    cyc(4'b0000, 4'b0000, 4'b0001, "R6 to r1");
    cyc(4'b0000, 4'b0000, 4'b0010, "R6 to r2");
    cyc(4'b0000, 4'b0000, 4'b0100, "R6 drain");
  endtask

  task automatic t_overlap;
    cyc(4'b0001, 4'b0000, 4'b0000, "R9 r0 after wrap");
    cyc(4'b0010, 4'b0000, 4'b0001, "R10 release with acquire");
    cyc(4'b0000, 4'b0000, 4'b0010, "R10 drain");
  endtask

  task automatic t_indep;
    cyc(4'b0011, 4'b0010, 4'b0000, "R11 two locks");
    cyc(4'b0100, 4'b0100, 4'b0000, "R11 r2 waits lock1");
    cyc(4'b0000, 4'b0000, 4'b0010, "R11 lock1 handoff");
    cyc(4'b0000, 4'b0000, 4'b0100, "R11 lock1 drain");
    cyc(4'b0000, 4'b0000, 4'b0001, "R11 lock0 drain");
  endtask

  task automatic t_wrap;
    for (int i = 0; i < 10; i++) begin
      cyc(4'b1000, 4'b1000, 4'b0000, "R9 wrap acquire");
      cyc(4'b0000, 4'b0000, 4'b1000, "R9 wrap release");
    end
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_single();
    t_simul();
    t_stray();
    t_overlap();
    t_indep();
    t_wrap();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule